// File: doc/BRIEF.md
# FM Operator Phase Generator

This block produces the phase of one FM synthesis operator. Each strobe supplies a pitch description: an 11-bit frequency number, a 3-bit octave, a 3-bit detune code, a 4-bit frequency multiplier, a 3-bit pitch-modulation depth and a 5-bit low-frequency oscillator (LFO) phase. The block turns these into a 20-bit phase step and adds that step to a 20-bit accumulator. The upper ten bits of the accumulator drive a downstream sine lookup.

The step is built in four stages. First, the frequency number is bent by an LFO pitch offset taken from two shift tables. Second, it is scaled by the octave. Third, a detune amount is added or subtracted; this amount depends on a key code made from the octave and a coarse note. Fourth, the result is multiplied by the frequency multiplier, where the setting zero means one half. A key-on clear input and a test-zero input each force the accumulator to zero. The block updates one operator for each strobe. The caller interleaves operators.

Top module: `fm_phase_gen`

## Requirements
- R1: After reset, `phase_o` and `step_o` are both zero.
- R2: All inputs are captured on a clock edge where `in_valid` is high. `step_o` and `phase_o` take the result at the next clock edge. In cycles with no captured strobe, both outputs hold their values.
- R3: The key code is the octave times 4 plus a note. The note comes from frequency-number bits 10:7, read as a value n: n of 6 or less gives 0, n=7 gives 1, n=8 gives 2, and n of 9 or more gives 3.
- R4: A multiplier setting of 0 acts as a factor of one half. A setting m from 1 to 15 acts as a factor of m. The step is (base × 2m, or × 1 for setting 0) shifted right by one, keeping the low 20 bits.
- R5: Detune bits 1:0 give a magnitude d. When d is 0, the detune is zero. Otherwise the key code k is limited to at most 28, and s = k/4 + 9 + a, where a is 0, 2 or 3 for d = 1, 2, 3. The detune is entry {s[0], k[1:0]} of the list 16,17,19,20,22,24,27,29, shifted right by 9 − s/2. Detune bit 2 set means the detune is subtracted, otherwise added. The base frequency is (modulated fnum << octave) >> 2 ± detune, kept to 17 bits.
- R6: The LFO pitch offset is computed from fnum>>4. This value is shifted right by two table entries, the row chosen by the depth and the column by the LFO magnitude. The LFO magnitude is LFO bits 2:0, inverted when LFO bit 3 is set. The two shifted values are summed and the sum is shifted right by 2. The modulated fnum is (fnum×2) plus the offset, or minus it when LFO bit 4 is set, kept to 12 bits.
- R7: For depths 6 and 7, the summed LFO offset is shifted left by 1 or 2 before the final shift right by 2.
- R8: The accumulator is 20 bits and wraps modulo 2^20. `phase_o` is its top 10 bits.
- R9: A captured strobe with `key_reset_i` high sets the accumulator to zero instead of adding. The step output still takes the new step.
- R10: A captured strobe with `zero_test_i` high sets the accumulator to zero in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe that captures all operand inputs |
| fnum_i | input | 11 | Frequency number |
| block_i | input | 3 | Octave |
| detune_i | input | 3 | Detune: bit 2 sign, bits 1:0 magnitude |
| mult_i | input | 4 | Frequency multiplier setting |
| pm_sens_i | input | 3 | LFO pitch-modulation depth |
| lfo_pm_i | input | 5 | LFO phase: bit 4 sign, bit 3 mirror, bits 2:0 magnitude |
| key_reset_i | input | 1 | Key-on clear of the accumulator |
| zero_test_i | input | 1 | Test control forcing the accumulator to zero |
| phase_o | output | 10 | Top bits of the phase accumulator |
| step_o | output | 20 | Most recent phase step |

## Verification
Two functions can fall on the same update: the accumulator clear (from key-on, from the test control, or from both) and the computation of a fresh step. The bench provokes this with strobes that carry a large nonzero step together with one or both clear inputs. It then checks that the phase reads zero while the step output shows the new step. The next strobe must then accumulate from zero. Strobes are sent back to back and also with idle gaps. A queue-based reference therefore judges, every cycle, both the one-edge latency and the holding of the outputs.

// File: rtl/fmpg_pkg.sv
package fmpg_pkg;

   localparam int FNUM_W = 11;
   localparam int BLK_W  = 3;
   localparam int DT_W   = 3;
   localparam int MUL_W  = 4;
   localparam int PMS_W  = 3;
   localparam int LFO_W  = 5;
   localparam int PH_W   = 20;
   localparam int OUT_W  = 10;
   localparam int BASE_W = 17;
   localparam int MOD_W  = FNUM_W + 1;
   localparam int KC_W   = BLK_W + 2;
   localparam int DET_W  = 5;
   localparam int MST_W  = MUL_W + 1;

   typedef logic [2:0] shamt_t;

   // first shift table, row = depth, column = LFO magnitude
   localparam shamt_t LFO_SH_A [8][8] = '{
      '{3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7},
      '{3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7},
      '{3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd1, 3'd1},
      '{3'd7, 3'd7, 3'd7, 3'd7, 3'd1, 3'd1, 3'd1, 3'd1},
      '{3'd7, 3'd7, 3'd7, 3'd1, 3'd1, 3'd1, 3'd1, 3'd0},
      '{3'd7, 3'd7, 3'd1, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0},
      '{3'd7, 3'd7, 3'd1, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0},
      '{3'd7, 3'd7, 3'd1, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0}
   };

   // second shift table, same indexing
   localparam shamt_t LFO_SH_B [8][8] = '{
      '{3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7},
      '{3'd7, 3'd7, 3'd7, 3'd7, 3'd2, 3'd2, 3'd2, 3'd2},
      '{3'd7, 3'd7, 3'd7, 3'd2, 3'd2, 3'd2, 3'd7, 3'd7},
      '{3'd7, 3'd7, 3'd2, 3'd2, 3'd7, 3'd7, 3'd2, 3'd2},
      '{3'd7, 3'd7, 3'd2, 3'd7, 3'd7, 3'd7, 3'd2, 3'd7},
      '{3'd7, 3'd7, 3'd7, 3'd2, 3'd7, 3'd7, 3'd2, 3'd1},
      '{3'd7, 3'd7, 3'd7, 3'd2, 3'd7, 3'd7, 3'd2, 3'd1},
      '{3'd7, 3'd7, 3'd7, 3'd2, 3'd7, 3'd7, 3'd2, 3'd1}
   };

   localparam logic [DET_W-1:0] DET_BASE [8] = '{
      5'd16, 5'd17, 5'd19, 5'd20, 5'd22, 5'd24, 5'd27, 5'd29
   };

   typedef struct packed {
      logic [FNUM_W-1:0] fnum;
      logic [BLK_W-1:0]  blk;
      logic [DT_W-1:0]   dt;
      logic [MUL_W-1:0]  mul;
      logic [PMS_W-1:0]  pms;
      logic [LFO_W-1:0]  lfo;
      logic              krst;
      logic              tzero;
   } pg_req_t;

   // coarse note from the four top frequency bits
   function automatic logic [1:0] note_of(input logic [3:0] hi);
      logic [1:0] n;
      if (hi < 4'd7)       n = 2'd0;
      else if (hi == 4'd7) n = 2'd1;
      else if (hi == 4'd8) n = 2'd2;
      else                 n = 2'd3;
      return n;
   endfunction

endpackage

// File: rtl/fmpg_lfo_mod.sv
module fmpg_lfo_mod
   import fmpg_pkg::*;
#(
   parameter int FW = FNUM_W,
   parameter int MW = FW + 1
) (
   input  logic [FW-1:0]    fnum_i,
   input  logic [PMS_W-1:0] pms_i,
   input  logic [LFO_W-1:0] lfo_i,
   output logic [MW-1:0]    mod_fnum_o
);

   localparam int SW = FW + 3;

   logic [2:0]    mag;
   logic [FW-1:0] coarse;
   shamt_t        sh_a, sh_b;
   logic [SW-1:0] pair_sum;
   logic [SW-1:0] scaled;
   logic [SW-1:0] offset;
   logic [SW-1:0] doubled;
   logic [SW-1:0] bent;

   always_comb begin
      mag    = lfo_i[3] ? ~lfo_i[2:0] : lfo_i[2:0];
      coarse = fnum_i >> 4;
      sh_a   = LFO_SH_A[pms_i][mag];
      sh_b   = LFO_SH_B[pms_i][mag];
      pair_sum = SW'(coarse >> sh_a) + SW'(coarse >> sh_b);
      if (pms_i > 3'd5) scaled = pair_sum << (pms_i - 3'd5);
      else              scaled = pair_sum;
      offset  = scaled >> 2;
      doubled = SW'({fnum_i, 1'b0});
      bent    = lfo_i[4] ? (doubled - offset) : (doubled + offset);
      mod_fnum_o = MW'(bent);
   end

endmodule

// File: rtl/fmpg_detune.sv
module fmpg_detune
   import fmpg_pkg::*;
(
   input  logic [KC_W-1:0]  kcode_i,
   input  logic [1:0]       mag_i,
   output logic [DET_W-1:0] det_o
);

   localparam logic [KC_W-1:0] KC_MAX = KC_W'(28);

   logic [KC_W-1:0] kc;
   logic [1:0]      extra;
   logic [4:0]      sum;
   logic [2:0]      idx;
   logic [3:0]      rsh;

   always_comb begin
      kc = (kcode_i > KC_MAX) ? KC_MAX : kcode_i;
      case (mag_i)
         2'd2:    extra = 2'd2;
         2'd3:    extra = 2'd3;
         default: extra = 2'd0;
      endcase
      sum = 5'(kc >> 2) + 5'd9 + 5'(extra);
      idx = {sum[0], kc[1:0]};
      rsh = 4'd9 - 4'(sum >> 1);
      det_o = (mag_i == 2'd0) ? '0 : (DET_BASE[idx] >> rsh);
   end

endmodule

// File: rtl/fmpg_step.sv
module fmpg_step
   import fmpg_pkg::*;
#(
   parameter int MW       = MOD_W,
   parameter int BW       = BASE_W,
   parameter int PW       = PH_W,
   parameter bit SHIFT_ADD = 1'b1
) (
   input  logic [MW-1:0]    mod_fnum_i,
   input  logic [BLK_W-1:0] blk_i,
   input  logic [DET_W-1:0] det_i,
   input  logic             det_neg_i,
   input  logic [MUL_W-1:0] mul_i,
   output logic [PW-1:0]    step_o
);

   localparam int XW = MW + (1 << BLK_W) - 1;
   localparam int PRW = BW + MST_W;

   logic [XW-1:0]    octaved;
   logic [BW-1:0]    base;
   logic [BW-1:0]    tuned;
   logic [MST_W-1:0] mstore;
   logic [PRW-1:0]   prod;

   always_comb begin
      octaved = XW'(mod_fnum_i) << blk_i;
      base    = BW'(octaved >> 2);
      tuned   = det_neg_i ? (base - BW'(det_i)) : (base + BW'(det_i));
      mstore  = (mul_i == '0) ? MST_W'(1) : {mul_i, 1'b0};
   end

   generate
      if (SHIFT_ADD) begin : g_shift_add
         logic [PRW-1:0] part [MST_W];
         for (genvar i = 0; i < MST_W; i++) begin : g_part
            assign part[i] = mstore[i] ? (PRW'(tuned) << i) : '0;
         end
         always_comb begin
            prod = '0;
            for (int j = 0; j < MST_W; j++) prod = prod + part[j];
         end
      end else begin : g_operator
         assign prod = PRW'(tuned) * PRW'(mstore);
      end
   endgenerate

   assign step_o = PW'(prod >> 1);

endmodule

// File: rtl/fmpg_accum.sv
module fmpg_accum #(
   parameter int PW = 20,
   parameter int OW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd_i,
   input  logic          clr_i,
   input  logic [PW-1:0] step_i,
   output logic [PW-1:0] step_o,
   output logic [OW-1:0] phase_o
);

   logic [PW-1:0] acc_q;
   logic [PW-1:0] step_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         step_q <= '0;
      end else if (upd_i) begin
         step_q <= step_i;
         acc_q  <= clr_i ? '0 : (acc_q + step_i);
      end
   end

   assign step_o  = step_q;
   assign phase_o = acc_q[PW-1 -: OW];

endmodule

// File: rtl/fm_phase_gen.sv
module fm_phase_gen
   import fmpg_pkg::*;
#(
   parameter int F_W       = FNUM_W,
   parameter int ACC_W     = PH_W,
   parameter int TOP_W     = OUT_W,
   parameter bit SHIFT_ADD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [F_W-1:0]   fnum_i,
   input  logic [BLK_W-1:0] block_i,
   input  logic [DT_W-1:0]  detune_i,
   input  logic [MUL_W-1:0] mult_i,
   input  logic [PMS_W-1:0] pm_sens_i,
   input  logic [LFO_W-1:0] lfo_pm_i,
   input  logic             key_reset_i,
   input  logic             zero_test_i,
   output logic [TOP_W-1:0] phase_o,
   output logic [ACC_W-1:0] step_o
);

   generate
      if (F_W != FNUM_W) begin : g_bad_fw
         $error("fm_phase_gen: frequency width must be %0d", FNUM_W);
      end
      if (ACC_W != PH_W) begin : g_bad_acc
         $error("fm_phase_gen: accumulator width must be %0d", PH_W);
      end
      if (TOP_W > ACC_W || TOP_W < 1) begin : g_bad_top
         $error("fm_phase_gen: output width out of range");
      end
   endgenerate

   pg_req_t req_q;
   logic    stage_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q   <= '0;
         stage_q <= 1'b0;
      end else begin
         stage_q <= in_valid;
         if (in_valid) begin
            req_q.fnum  <= fnum_i;
            req_q.blk   <= block_i;
            req_q.dt    <= detune_i;
            req_q.mul   <= mult_i;
            req_q.pms   <= pm_sens_i;
            req_q.lfo   <= lfo_pm_i;
            req_q.krst  <= key_reset_i;
            req_q.tzero <= zero_test_i;
         end
      end
   end

   logic [KC_W-1:0]  kcode;
   logic [MOD_W-1:0] mod_fnum;
   logic [DET_W-1:0] det;
   logic [ACC_W-1:0] step_next;

   assign kcode = {req_q.blk, note_of(req_q.fnum[F_W-1 -: 4])};

   fmpg_lfo_mod #(.FW(F_W), .MW(MOD_W)) u_lfo (
      .fnum_i     (req_q.fnum),
      .pms_i      (req_q.pms),
      .lfo_i      (req_q.lfo),
      .mod_fnum_o (mod_fnum)
   );

   fmpg_detune u_det (
      .kcode_i (kcode),
      .mag_i   (req_q.dt[1:0]),
      .det_o   (det)
   );

   fmpg_step #(.MW(MOD_W), .BW(BASE_W), .PW(ACC_W), .SHIFT_ADD(SHIFT_ADD)) u_step (
      .mod_fnum_i (mod_fnum),
      .blk_i      (req_q.blk),
      .det_i      (det),
      .det_neg_i  (req_q.dt[2]),
      .mul_i      (req_q.mul),
      .step_o     (step_next)
   );

   fmpg_accum #(.PW(ACC_W), .OW(TOP_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_i   (stage_q),
      .clr_i   (req_q.krst | req_q.tzero),
      .step_i  (step_next),
      .step_o  (step_o),
      .phase_o (phase_o)
   );

endmodule

// File: rtl/fmpg_chk.sv
module fmpg_chk #(
   parameter int FW = 11,
   parameter int OW = 10,
   parameter int PW = 20
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [FW-1:0] fnum_i,
   input logic          stage_q,
   input logic [FW-1:0] cap_fnum,
   input logic          krst_q,
   input logic          tzero_q,
   input logic [OW-1:0] phase_o,
   input logic [PW-1:0] step_o
);

   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (cap_fnum == $past(fnum_i)));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !stage_q |=> ($stable(phase_o) && $stable(step_o)));

   p_keyclear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q && krst_q) |=> (phase_o == '0));

   p_testzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q && tzero_q) |=> (phase_o == '0));

endmodule

bind fm_phase_gen fmpg_chk #(.FW(F_W), .OW(TOP_W), .PW(ACC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .fnum_i   (fnum_i),
   .stage_q  (stage_q),
   .cap_fnum (req_q.fnum),
   .krst_q   (req_q.krst),
   .tzero_q  (req_q.tzero),
   .phase_o  (phase_o),
   .step_o   (step_o)
);

// File: tb/fm_phase_gen_tb_top.sv
module fm_phase_gen_tb_top;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [10:0] fnum_i = '0;
   logic [2:0]  block_i = '0;
   logic [2:0]  detune_i = '0;
   logic [3:0]  mult_i = '0;
   logic [2:0]  pm_sens_i = '0;
   logic [4:0]  lfo_pm_i = '0;
   logic        key_reset_i = 1'b0;
   logic        zero_test_i = 1'b0;
   logic [9:0]  phase_o;
   logic [19:0] step_o;

   always #(CLK_P/2) clk = ~clk;

   fm_phase_gen dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fnum_i(fnum_i),
      .block_i(block_i), .detune_i(detune_i), .mult_i(mult_i),
      .pm_sens_i(pm_sens_i), .lfo_pm_i(lfo_pm_i), .key_reset_i(key_reset_i),
      .zero_test_i(zero_test_i), .phase_o(phase_o), .step_o(step_o)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   int    cyc = 0;
   bit    running = 1'b0;
   bit    finished = 1'b0;
   int    q_due[$];
   int    q_inc[$];
   int    q_ph[$];
   string q_tag[$];
   int    m_phase = 0;
   int    e_inc = 0;
   int    e_ph = 0;
   string e_tag = "R1";
   int    seed = 7;

   // row words, column 0 in the top nibble
   int unsigned tab_a [8] = '{32'h77777777, 32'h77777777, 32'h77777711, 32'h77771111,
                              32'h77711110, 32'h77110000, 32'h77110000, 32'h77110000};
   int unsigned tab_b [8] = '{32'h77777777, 32'h77772222, 32'h77722277, 32'h77227722,
                              32'h77277727, 32'h77727721, 32'h77727721, 32'h77727721};
   int dlist [8] = '{16, 17, 19, 20, 22, 24, 27, 29};

   function automatic int nib(int unsigned w, int col);
      return int'((w >> (4 * (7 - col))) & 4'hf);
   endfunction

   function automatic int ref_step(int f, int b, int d, int m, int p, int l);
      int fh, mg, ofs, mf, hi, nt, kc, k, s, dm, det, bf, mu, add;
      fh  = f >> 4;
      mg  = ((l & 8) != 0) ? ((~l) & 7) : (l & 7);
      ofs = (fh >> nib(tab_a[p], mg)) + (fh >> nib(tab_b[p], mg));
      if (p > 5) ofs = ofs << (p - 5);
      ofs = ofs >> 2;
      mf  = ((l & 16) != 0) ? (2 * f - ofs) : (2 * f + ofs);
      mf  = mf & 'hfff;
      hi  = f >> 7;
      nt  = (hi <= 6) ? 0 : (hi == 7) ? 1 : (hi == 8) ? 2 : 3;
      kc  = b * 4 + nt;
      dm  = d & 3;
      det = 0;
      if (dm != 0) begin
         k   = (kc > 28) ? 28 : kc;
         add = (dm == 3) ? 3 : (dm == 2) ? 2 : 0;
         s   = k / 4 + 9 + add;
         det = dlist[(s % 2) * 4 + (k % 4)] >> (9 - s / 2);
      end
      bf = (mf << b) >> 2;
      bf = ((d & 4) != 0) ? (bf - det) : (bf + det);
      bf = bf & 'h1ffff;
      mu = (m == 0) ? 1 : 2 * m;
      return ((bf * mu) >> 1) & 'hfffff;
   endfunction

   always @(posedge clk) cyc <= cyc + 1;

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (running) begin
         while (q_due.size() > 0 && q_due[0] <= cyc) begin
            void'(q_due.pop_front());
            e_inc = q_inc.pop_front();
            e_ph  = q_ph.pop_front();
            e_tag = q_tag.pop_front();
         end
         n_chk++;
         if (int'(step_o) != e_inc || int'(phase_o) != (e_ph >> 10)) begin
            n_bad++;
            $display("FAIL %s cycle %0d: step %0d phase %0d, expected step %0d phase %0d",
                     e_tag, cyc, step_o, phase_o, e_inc, e_ph >> 10);
         end
      end
   end

   task automatic drive(int f, int b, int d, int m, int p, int l, bit kr, bit tz, string tag);
      int s;
      @(negedge clk);
      fnum_i = 11'(f); block_i = 3'(b); detune_i = 3'(d); mult_i = 4'(m);
      pm_sens_i = 3'(p); lfo_pm_i = 5'(l); key_reset_i = kr; zero_test_i = tz;
      in_valid = 1'b1;
      s = ref_step(f, b, d, m, p, l);
      m_phase = (kr || tz) ? 0 : ((m_phase + s) & 'hfffff);
      q_due.push_back(cyc + 2);
      q_inc.push_back(s);
      q_ph.push_back(m_phase);
      q_tag.push_back(tag);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         fnum_i = 11'h5a5; key_reset_i = 1'b1; zero_test_i = 1'b1;
      end
   endtask

   function automatic int rnd(int span);
      seed = seed * 1103515245 + 12345;
      return ((seed >>> 8) & 32'h7fffff) % span;
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_chk++;
      if (phase_o != '0 || step_o != '0) begin
         n_bad++;
         $display("FAIL R1 reset state: step %0d phase %0d, expected 0 0", step_o, phase_o);
      end
      running = 1'b1;

      // R3 note table across all top nibbles, with detune active
      for (int h = 0; h < 16; h++) drive((h << 7) | 37, 4, 3, 1, 0, 0, 0, 0, "R3");
      idle(3);
      // R4 every multiplier setting
      for (int m = 0; m < 16; m++) drive(1234, 3, 0, m, 0, 0, 0, 0, "R4");
      idle(2);
      // R5 detune codes over octaves, including subtract wrap at tiny fnum
      for (int b = 0; b < 8; b++)
         for (int d = 0; d < 8; d++) drive(1900 - b * 37, b, d, 1, 0, 0, 0, 0, "R5");
      for (int d = 4; d < 8; d++) drive(0, 7, d, 3, 0, 0, 0, 0, "R5");
      idle(2);
      // R6 every LFO phase at depths 1..5
      for (int p = 1; p < 6; p++)
         for (int l = 0; l < 32; l++) drive(2047 - l * 9, 2, 0, 2, p, l, 0, 0, "R6");
      // R7 deep settings
      for (int p = 6; p < 8; p++)
         for (int l = 0; l < 32; l++) drive(1500 + l * 17, 5, 1, 1, p, l, 0, 0, "R7");
      idle(2);
      // R8 large steps forcing repeated wrap
      for (int i = 0; i < 24; i++) drive(2047, 7, 0, 15, 0, 0, 0, 0, "R8");
      // R9 key clear coinciding with a new step, then accumulate from zero
      drive(2047, 7, 2, 13, 0, 0, 1, 0, "R9");
      drive(900, 6, 1, 5, 0, 0, 0, 0, "R9");
      drive(900, 6, 1, 5, 0, 0, 0, 0, "R9");
      idle(1);
      // R10 test zero alone and together with key clear
      drive(1777, 6, 6, 9, 3, 11, 0, 1, "R10");
      drive(1111, 5, 0, 4, 0, 0, 0, 0, "R10");
      drive(1999, 7, 3, 7, 7, 21, 1, 1, "R10");
      drive(1999, 7, 3, 7, 7, 21, 0, 0, "R10");
      idle(3);
      // R2 mixed traffic with random gaps
      for (int i = 0; i < 300; i++) begin
         drive(rnd(2048), rnd(8), rnd(8), rnd(16), rnd(8), rnd(32),
               rnd(16) == 0, rnd(23) == 0, "R2");
         if (rnd(4) == 0) idle(1 + rnd(3));
      end
      idle(4);
      running = 1'b0;
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL R2 watchdog expired");
         summary();
         $finish;
      end
   end

endmodule